// File: doc/BRIEF.md
# Threshold FIFO with DMA Requests

This block is a 32-word, 16-bit circular buffer sitting between a host bus and a card-side byte engine. The transfer direction picks which side fills it and which side drains it: in receive the card side pushes and the bus reads; in transmit the bus writes and the card side pops. The other side's requests are ignored.

Two programmable 5-bit thresholds watch the fill count. In receive, a fill count above the upper threshold asks for service. In transmit, a fill count below the lower threshold asks for service. Each direction has an enable that sends the request either to a DMA request line or to a status flag, never to both. When no transfer is running and the buffer is empty, both flags are forced low.

Occupancy is tracked by a three-state machine: `OCC_EMPTY`, `OCC_PART` and `OCC_FULL`.
- `EMPTY→PART` on an accepted write.
- `PART→FULL` on a lone write at 31 words.
- `PART→EMPTY` on a lone read at 1 word.
- `FULL→PART` on any accepted read.

A write into a full buffer is dropped and reported by a one-cycle overrun pulse. A read from an empty buffer is reported by a one-cycle underrun pulse and leaves the indices alone.

Top module: `wm_threshold_fifo`

## Requirements
- R1: After reset the fill count is 0, every request, flag and pulse is 0, the upper threshold is 31 and the lower threshold is 0.
- R2: Words leave in the order they were accepted, including across the wrap of the 32-entry index space.
- R3: A write while 32 words are held is discarded. The count stays 32 and `overrun_pulse` is 1 for exactly the following cycle.
- R4: A read while empty leaves the count at 0 and the read index unchanged, and raises `underrun_pulse` for the following cycle.
- R5: With `dir_rx`=1 only `card_push` writes and only `bus_rd_en` reads. With `dir_rx`=0 only `bus_wr_en` writes and only `card_pop` reads. Requests from the other side change nothing.
- R6: With `dir_rx`=1 and the fill count strictly greater than the upper threshold, `rx_dma_req` is 1 if `rx_dma_en`=1; otherwise `rx_lvl_flag` is 1.
- R7: With `dir_rx`=0 and the fill count strictly less than the lower threshold, `tx_dma_req` is 1 if `tx_dma_en`=1; otherwise `tx_lvl_flag` is 1.
- R8: With `xfer_active`=0 and a fill count of 0, both level flags and both requests are 0.
- R9: When a direction's condition is not met, or the other direction is selected, that direction's request and flag are 0. A set DMA enable holds its flag at 0.
- R10: A cycle with `lvl_wr`=1 loads both thresholds, and they take effect from the next cycle.
- R11: An accepted write and an accepted read in the same cycle leave the count unchanged. At 32 words the write is dropped, the read is taken and the count becomes 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1 = receive (card fills, bus drains), 0 = transmit |
| xfer_active | input | 1 | Transfer in progress |
| rx_dma_en | input | 1 | Receive threshold goes to DMA request instead of flag |
| tx_dma_en | input | 1 | Transmit threshold goes to DMA request instead of flag |
| lvl_wr | input | 1 | Load both thresholds |
| full_lvl_in | input | 5 | New upper threshold |
| empty_lvl_in | input | 5 | New lower threshold |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_data | input | 16 | Bus write word |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_rd_data | output | 16 | Head word for the bus |
| card_push | input | 1 | Card-side push strobe |
| card_push_data | input | 16 | Card-side push word |
| card_pop | input | 1 | Card-side pop strobe |
| card_pop_data | output | 16 | Head word for the card side |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_lvl_flag | output | 1 | Receive threshold status |
| tx_lvl_flag | output | 1 | Transmit threshold status |
| fill_count | output | 6 | Words held, 0 to 32 |
| overrun_pulse | output | 1 | Dropped write, one cycle |
| underrun_pulse | output | 1 | Read while empty, one cycle |

## Verification
A write and a read can arrive in the same cycle. That matters most at the two edges of occupancy, where one of them is refused while the other is taken. The bench fills the buffer to 32 and then strobes write and pop together; it expects a count of 31, an overrun pulse and the oldest word popped. It also strobes both together at partial fill and expects the count to hold while the head advances. For the empty edge, it reads an empty buffer, then pushes, and expects the pushed word to be the first one returned.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

    typedef struct packed {
        logic rx_req;
        logic rx_flag;
        logic tx_req;
        logic tx_flag;
    } lvl_out_t;

endpackage

// File: rtl/wm_fifo_store.sv
module wm_fifo_store
    import wm_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          ovr_pulse,
    output logic          udr_pulse
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    occ_state_e    state_q, state_d;
    logic          wr_ok, rd_ok;

    assign wr_ok   = wr_req && (state_q != OCC_FULL);
    assign rd_ok   = rd_req && (state_q != OCC_EMPTY);
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: if (wr_ok) state_d = OCC_PART;
            OCC_PART: begin
                if (wr_ok && !rd_ok && count == CW'(DEPTH - 1))
                    state_d = OCC_FULL;
                else if (rd_ok && !wr_ok && count == CW'(1))
                    state_d = OCC_EMPTY;
            end
            OCC_FULL:  if (rd_ok) state_d = OCC_PART;
            default:   state_d = OCC_EMPTY;
        endcase
    end

    // indices, count and pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            ovr_pulse <= 1'b0;
            udr_pulse <= 1'b0;
        end else begin
            ovr_pulse <= wr_req && (state_q == OCC_FULL);
            udr_pulse <= rd_req && (state_q == OCC_EMPTY);
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && wr_req && !rd_req) |=> (count == CW'(DEPTH))); // R3
    AST_OVR_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> ($past(count) == CW'(DEPTH))); // R3
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_req && !wr_req) |=> (count == '0 && $stable(rd_ptr))); // R4
    AST_STATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (count == '0)); // R2
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req && count > '0 && count < CW'(DEPTH)) |=> $stable(count)); // R11

endmodule

// File: rtl/wm_level_ctl.sv
module wm_level_ctl
    import wm_fifo_pkg::*;
#(
    parameter int LW = 5,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_wr,
    input  logic [LW-1:0] full_lvl_in,
    input  logic [LW-1:0] empty_lvl_in,
    input  logic          dir_rx,
    input  logic          xfer_active,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    input  logic [CW-1:0] count,
    output lvl_out_t      lvl_out
);
    logic [LW-1:0] full_q, empty_q;
    logic          rx_hit, tx_hit, idle_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q  <= '1;
            empty_q <= '0;
        end else if (lvl_wr) begin
            full_q  <= full_lvl_in;
            empty_q <= empty_lvl_in;
        end
    end

    assign idle_empty = !xfer_active && (count == '0);
    assign rx_hit     = dir_rx  && (count > CW'(full_q));
    assign tx_hit     = !dir_rx && (count < CW'(empty_q));

    always_comb begin
        lvl_out = '0;
        if (!idle_empty) begin
            lvl_out.rx_req  = rx_hit &&  rx_dma_en;
            lvl_out.rx_flag = rx_hit && !rx_dma_en;
            lvl_out.tx_req  = tx_hit &&  tx_dma_en;
            lvl_out.tx_flag = tx_hit && !tx_dma_en;
        end
    end

    AST_RX_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvl_out.rx_req && lvl_out.rx_flag)); // R9
    AST_TX_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvl_out.tx_req && lvl_out.tx_flag)); // R9
    AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx |-> !(lvl_out.tx_req || lvl_out.tx_flag)); // R9
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && count == '0) |-> (lvl_out == '0)); // R8
    AST_RX_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_out.rx_req || lvl_out.rx_flag) |-> (count != '0)); // R6

endmodule

// File: rtl/wm_threshold_fifo.sv
module wm_threshold_fifo
    import wm_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int LW    = 5,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_rx,
    input  logic          xfer_active,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    input  logic          lvl_wr,
    input  logic [LW-1:0] full_lvl_in,
    input  logic [LW-1:0] empty_lvl_in,
    input  logic          bus_wr_en,
    input  logic [DW-1:0] bus_wr_data,
    input  logic          bus_rd_en,
    output logic [DW-1:0] bus_rd_data,
    input  logic          card_push,
    input  logic [DW-1:0] card_push_data,
    input  logic          card_pop,
    output logic [DW-1:0] card_pop_data,
    output logic          rx_dma_req,
    output logic          tx_dma_req,
    output logic          rx_lvl_flag,
    output logic          tx_lvl_flag,
    output logic [CW-1:0] fill_count,
    output logic          overrun_pulse,
    output logic          underrun_pulse
);
    logic          wr_req, rd_req;
    logic [DW-1:0] wr_data, head;
    lvl_out_t      lvl;

    // direction routing: receive fills from card, drains to bus
    assign wr_req  = dir_rx ? card_push      : bus_wr_en;
    assign wr_data = dir_rx ? card_push_data : bus_wr_data;
    assign rd_req  = dir_rx ? bus_rd_en      : card_pop;

    wm_fifo_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_data   (head),
        .count     (fill_count),
        .ovr_pulse (overrun_pulse),
        .udr_pulse (underrun_pulse)
    );

    wm_level_ctl #(.LW(LW), .CW(CW)) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_wr       (lvl_wr),
        .full_lvl_in  (full_lvl_in),
        .empty_lvl_in (empty_lvl_in),
        .dir_rx       (dir_rx),
        .xfer_active  (xfer_active),
        .rx_dma_en    (rx_dma_en),
        .tx_dma_en    (tx_dma_en),
        .count        (fill_count),
        .lvl_out      (lvl)
    );

    assign bus_rd_data   = head;
    assign card_pop_data = head;
    assign rx_dma_req    = lvl.rx_req;
    assign rx_lvl_flag   = lvl.rx_flag;
    assign tx_dma_req    = lvl.tx_req;
    assign tx_lvl_flag   = lvl.tx_flag;

    AST_RX_IGNORES_BUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rx && bus_wr_en && !card_push && !bus_rd_en) |=> $stable(fill_count)); // R5
    AST_TX_IGNORES_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_rx && card_push && !bus_wr_en && !card_pop) |=> $stable(fill_count)); // R5

endmodule

// File: tb/wm_threshold_fifo_bench.sv
`timescale 1ns/1ps
module wm_threshold_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_rx, xfer_active, rx_dma_en, tx_dma_en, lvl_wr;
    logic [4:0]  full_lvl_in, empty_lvl_in;
    logic        bus_wr_en, bus_rd_en, card_push, card_pop;
    logic [15:0] bus_wr_data, card_push_data, bus_rd_data, card_pop_data;
    logic        rx_dma_req, tx_dma_req, rx_lvl_flag, tx_lvl_flag;
    logic [5:0]  fill_count;
    logic        overrun_pulse, underrun_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wm_threshold_fifo u_wm_threshold_fifo (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .xfer_active(xfer_active),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en), .lvl_wr(lvl_wr),
        .full_lvl_in(full_lvl_in), .empty_lvl_in(empty_lvl_in),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .card_push(card_push), .card_push_data(card_push_data),
        .card_pop(card_pop), .card_pop_data(card_pop_data),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_lvl_flag(rx_lvl_flag), .tx_lvl_flag(tx_lvl_flag),
        .fill_count(fill_count), .overrun_pulse(overrun_pulse),
        .underrun_pulse(underrun_pulse)
    );

    // {dir_rx, rx_en, tx_en, xfer, full_lvl[5], empty_lvl[5], fill[6], exp{rxreq,rxflag,txreq,txflag}}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 1'b1, 5'd4,  5'd0, 6'd5,  4'b1000},
        {1'b1, 1'b0, 1'b0, 1'b1, 5'd4,  5'd0, 6'd5,  4'b0100},
        {1'b1, 1'b1, 1'b0, 1'b1, 5'd4,  5'd0, 6'd4,  4'b0000},
        {1'b0, 1'b0, 1'b1, 1'b1, 5'd31, 5'd3, 6'd2,  4'b0010},
        {1'b0, 1'b0, 1'b0, 1'b1, 5'd31, 5'd3, 6'd2,  4'b0001},
        {1'b0, 1'b0, 1'b1, 1'b1, 5'd31, 5'd3, 6'd3,  4'b0000},
        {1'b0, 1'b0, 1'b0, 1'b0, 5'd31, 5'd3, 6'd0,  4'b0000},
        {1'b0, 1'b0, 1'b0, 1'b1, 5'd31, 5'd3, 6'd0,  4'b0001},
        {1'b1, 1'b0, 1'b0, 1'b1, 5'd31, 5'd0, 6'd32, 4'b0100},
        {1'b1, 1'b1, 1'b0, 1'b1, 5'd0,  5'd0, 6'd1,  4'b1000},
        {1'b1, 1'b0, 1'b0, 1'b0, 5'd0,  5'd0, 6'd1,  4'b0100},
        {1'b0, 1'b1, 1'b1, 1'b1, 5'd0,  5'd5, 6'd1,  4'b0010}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        bus_wr_en = 0; bus_rd_en = 0; card_push = 0; card_pop = 0; lvl_wr = 0;
    endtask

    task automatic do_reset();
        clear_strobes();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic load_levels(input logic [4:0] fl, input logic [4:0] el);
        full_lvl_in = fl; empty_lvl_in = el; lvl_wr = 1;
        tick();
        lvl_wr = 0;
    endtask

    task automatic push_word(input logic [15:0] d);
        if (dir_rx) begin card_push = 1; card_push_data = d; end
        else begin bus_wr_en = 1; bus_wr_data = d; end
        tick();
        card_push = 0; bus_wr_en = 0;
    endtask

    task automatic pop_check(input string tag, input logic [15:0] exp);
        if (dir_rx) begin
            check(tag, 32'(bus_rd_data), 32'(exp));
            bus_rd_en = 1;
        end else begin
            check(tag, 32'(card_pop_data), 32'(exp));
            card_pop = 1;
        end
        tick();
        bus_rd_en = 0; card_pop = 0;
    endtask

    function automatic logic [3:0] lvl_bits();
        return {rx_dma_req, rx_lvl_flag, tx_dma_req, tx_lvl_flag};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        dir_rx = 1; xfer_active = 1; rx_dma_en = 0; tx_dma_en = 0;
        full_lvl_in = 0; empty_lvl_in = 0;
        bus_wr_data = 0; card_push_data = 0;
        clear_strobes();

        // R1: reset state and default thresholds
        do_reset();
        check("R1 fill after reset", 32'(fill_count), 0);
        check("R1 outputs after reset", 32'({lvl_bits(), overrun_pulse, underrun_pulse}), 0);
        for (int k = 0; k < 31; k++) push_word(16'(k));
        check("R1 default upper level, 31 words", 32'(lvl_bits()), 32'b0000);
        push_word(16'h55);
        check("R1 default upper level, 32 words", 32'(lvl_bits()), 32'b0100);
        dir_rx = 0;
        do_reset();
        check("R1 default lower level is 0", 32'(lvl_bits()), 32'b0000);

        // table of threshold scenarios: R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            dir_rx = v[23]; rx_dma_en = v[22]; tx_dma_en = v[21]; xfer_active = v[20];
            do_reset();
            load_levels(v[19:15], v[14:10]);
            for (int k = 0; k < int'(v[9:4]); k++) push_word(16'(k));
            check($sformatf("R6 R7 R8 R9 R10 vector %0d", i), 32'(lvl_bits()), 32'(v[3:0]));
        end

        // R2: order across index wrap
        dir_rx = 0; xfer_active = 1; rx_dma_en = 0; tx_dma_en = 0;
        do_reset();
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 20; k++) push_word(16'hA000 + 16'(r * 20 + k));
            for (int k = 0; k < 20; k++) pop_check("R2 order across wrap", 16'hA000 + 16'(r * 20 + k));
        end
        check("R2 empty after drain", 32'(fill_count), 0);

        // R3: overrun
        for (int k = 0; k < 32; k++) push_word(16'hB000 + 16'(k));
        check("R3 full count", 32'(fill_count), 32);
        push_word(16'hDEAD);
        check("R3 count stays 32", 32'(fill_count), 32);
        check("R3 overrun pulse", 32'(overrun_pulse), 1);
        tick();
        check("R3 overrun pulse one cycle", 32'(overrun_pulse), 0);

        // R11: write and read together while full
        bus_wr_en = 1; bus_wr_data = 16'hBEEF; card_pop = 1;
        check("R11 head while full", 32'(card_pop_data), 32'hB000);
        tick();
        clear_strobes();
        check("R11 full both -> 31", 32'(fill_count), 31);
        check("R11 full both overrun", 32'(overrun_pulse), 1);
        check("R11 next head", 32'(card_pop_data), 32'hB001);
        bus_wr_en = 1; bus_wr_data = 16'hC001; card_pop = 1;
        tick();
        clear_strobes();
        check("R11 partial both count", 32'(fill_count), 31);
        check("R11 partial both head", 32'(card_pop_data), 32'hB002);

        // R4: underrun
        do_reset();
        card_pop = 1;
        tick();
        clear_strobes();
        check("R4 count stays 0", 32'(fill_count), 0);
        check("R4 underrun pulse", 32'(underrun_pulse), 1);
        push_word(16'h1234);
        check("R4 underrun pulse one cycle", 32'(underrun_pulse), 0);
        pop_check("R4 indices unchanged", 16'h1234);

        // R5: routing in receive direction
        dir_rx = 1;
        do_reset();
        bus_wr_en = 1; bus_wr_data = 16'h9999;
        tick();
        clear_strobes();
        check("R5 bus write ignored in receive", 32'(fill_count), 0);
        push_word(16'h4321);
        card_pop = 1;
        tick();
        clear_strobes();
        check("R5 card pop ignored in receive", 32'(fill_count), 1);
        pop_check("R5 bus read drains receive", 16'h4321);
        dir_rx = 0;
        card_push = 1; card_push_data = 16'h7777;
        tick();
        clear_strobes();
        check("R5 card push ignored in transmit", 32'(fill_count), 0);

        summary();
        $finish;
    end
endmodule